// File: doc/BRIEF.md
# Tile-Triggered Latch Character Bank Switcher

This block is a cartridge mapper for a game console. The CPU writes a set of bank registers through the upper half of its address space. The block then turns CPU program addresses and video pattern-fetch addresses into addresses for the program ROM and the character ROM. The program window holds one switchable 8 KB bank, and the three 8 KB windows above it are fixed to the last banks of the ROM.

Each 4 KB half of the character space has two candidate banks. A one-bit latch per half picks which of the two is in use. The latch flips by itself when the video processor fetches pattern data for one of two marker tiles, so the picture can change banks partway through a frame with no CPU work. A mirroring bit chooses how the nametable pages map onto the console's internal video RAM.

Top module: `tile_latch_mapper`

## Requirements
- R1: After reset both latches select their tile-$FE bank, all four character bank registers and the program bank select are 0, and mirroring is vertical (`mirror_horiz`=0).
- R2: A CPU write with address bits 15:12 = 4'hA loads data bits 3:0 into the program bank select. CPU addresses $8000-$9FFF then map to `prg_rom_addr` = {select, cpu_addr[12:0]}.
- R3: CPU addresses $A000-$BFFF, $C000-$DFFF and $E000-$FFFF map to the fixed 8 KB banks N-3, N-2 and N-1, where N = 2**PRG_BANK_BITS (13, 14 and 15 by default).
- R4: Writes with address bits 15:12 = B, C, D or E load data bits CHR_BANK_BITS-1:0 into, in turn, the lower-half FD bank, the lower-half FE bank, the upper-half FD bank and the upper-half FE bank. The new value shows on the next fetch only if that half's latch selects that register. Otherwise the output does not change.
- R5: On a cycle with `ppu_rd`=1, a fetch address whose bits 11:4 are 8'hFD sets the latch of the half picked by bit 12 (0 = lower, 1 = upper) to FD, and 8'hFE sets it to FE. The fetch that triggers the change still uses the old bank, and the new bank applies from the next fetch. Other tiles, the other half's latch, and addresses presented with `ppu_rd`=0 leave the latch unchanged.
- R6: `chr_rom_addr` = {selected 4 KB bank of the half chosen by ppu_addr[12], ppu_addr[11:0]}. It is combinational from the current state.
- R7: A write with address bits 15:12 = 4'hF sets `mirror_horiz` from data bit 0 (1 = horizontal, 0 = vertical). `nt_page` equals ppu_addr[11] when horizontal and ppu_addr[10] when vertical.
- R8: CPU writes below $A000 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address, used both to decode writes and to translate program addresses |
| cpu_data | input | 8 | CPU write data |
| ppu_rd | input | 1 | Pattern fetch strobe |
| ppu_addr | input | 14 | Video address |
| prg_rom_addr | output | PRG_BANK_BITS+13 | Program ROM address |
| chr_rom_addr | output | CHR_BANK_BITS+12 | Character ROM address |
| mirror_horiz | output | 1 | 1 = horizontal mirroring |
| nt_page | output | 1 | Internal video RAM page select |

## Verification
All register writes and latch flips take effect at the clock edge that samples the strobe. The address outputs are combinational from the state, so a result is due in the first cycle after the stimulus. The bench drives inputs on the falling edge and samples the outputs shortly after, before the next rising edge. For a latch-flipping fetch, the output is sampled during the fetch itself to see the old bank, and again on the following fetch to see the new one. Register writes to a half whose latch selects the other register are followed by a fetch, which shows that the visible address did not change.

// File: rtl/tile_latch_mapper.sv
module tile_latch_mapper #(
  parameter int PRG_BANK_BITS = 4,
  parameter int CHR_BANK_BITS = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_we,
  input  logic [15:0]               cpu_addr,
  input  logic [7:0]                cpu_data,
  input  logic                      ppu_rd,
  input  logic [13:0]               ppu_addr,
  output logic [PRG_BANK_BITS+12:0] prg_rom_addr,
  output logic [CHR_BANK_BITS+11:0] chr_rom_addr,
  output logic                      mirror_horiz,
  output logic                      nt_page
);
  localparam int PB = PRG_BANK_BITS;
  localparam int CB = CHR_BANK_BITS;
  localparam logic [PB-1:0] LAST = PB'((1 << PB) - 1);
  localparam logic [7:0] TILE_FD = 8'hFD;
  localparam logic [7:0] TILE_FE = 8'hFE;

  logic [3:0]    prg_sel;
  logic [CB-1:0] lo_fd, lo_fe, hi_fd, hi_fe;
  logic          lo_is_fe, hi_is_fe;

  wire [3:0] wsel = cpu_addr[15:12];
  wire [7:0] tile = ppu_addr[11:4];
  wire       hit_fd = ppu_rd && tile == TILE_FD;
  wire       hit_fe = ppu_rd && tile == TILE_FE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_sel      <= '0;
      lo_fd        <= '0;
      lo_fe        <= '0;
      hi_fd        <= '0;
      hi_fe        <= '0;
      mirror_horiz <= 1'b0;
    end else if (cpu_we) begin
      case (wsel)
        4'hA: prg_sel      <= cpu_data[3:0];
        4'hB: lo_fd        <= cpu_data[CB-1:0];
        4'hC: lo_fe        <= cpu_data[CB-1:0];
        4'hD: hi_fd        <= cpu_data[CB-1:0];
        4'hE: hi_fe        <= cpu_data[CB-1:0];
        4'hF: mirror_horiz <= cpu_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_is_fe <= 1'b1;
      hi_is_fe <= 1'b1;
    end else if (hit_fd || hit_fe) begin
      if (ppu_addr[12]) hi_is_fe <= hit_fe;
      else              lo_is_fe <= hit_fe;
    end
  end

  logic [PB-1:0] prg_bank;
  always_comb begin
    case (cpu_addr[14:13])
      2'd0:    prg_bank = PB'(prg_sel);
      2'd1:    prg_bank = LAST - PB'(2);
      2'd2:    prg_bank = LAST - PB'(1);
      default: prg_bank = LAST;
    endcase
  end
  assign prg_rom_addr = {prg_bank, cpu_addr[12:0]};

  wire [CB-1:0] lo_bank = lo_is_fe ? lo_fe : lo_fd;
  wire [CB-1:0] hi_bank = hi_is_fe ? hi_fe : hi_fd;
  assign chr_rom_addr = {ppu_addr[12] ? hi_bank : lo_bank, ppu_addr[11:0]};
  assign nt_page = mirror_horiz ? ppu_addr[11] : ppu_addr[10];

  // R1
  reset_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (lo_is_fe && hi_is_fe && prg_sel == 4'd0 && !mirror_horiz));
  // R2
  prg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && wsel == 4'hA) |=> prg_sel == $past(cpu_data[3:0]));
  // R3
  last_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> prg_rom_addr[PB+12:13] == LAST);
  // R4
  lo_fe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && wsel == 4'hC) |=> lo_fe == $past(cpu_data[CB-1:0]));
  // R5
  fd_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_fd && !ppu_addr[12]) |=> !lo_is_fe);
  // R5
  latch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ppu_rd) |=> ($stable(lo_is_fe) && $stable(hi_is_fe)));
  // R7
  mirror_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && wsel == 4'hF) |=> mirror_horiz == $past(cpu_data[0]));
  // R8
  low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !cpu_addr[15]) |=> ($stable(prg_sel) && $stable(lo_fd) && $stable(hi_fe)));
endmodule

// File: tb/tile_latch_mapper_tb.sv
module tile_latch_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_data = 8'h0;
  logic        ppu_rd = 1'b0;
  logic [13:0] ppu_addr = 14'h0;
  logic [16:0] prg_rom_addr;
  logic [16:0] chr_rom_addr;
  logic        mirror_horiz;
  logic        nt_page;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  tile_latch_mapper u_dut (.*);

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_data = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  // one pattern fetch; returns the address seen during the fetch
  task automatic fetch(input logic [13:0] a, output logic [16:0] seen);
    @(negedge clk);
    ppu_rd = 1'b1; ppu_addr = a;
    #1 seen = chr_rom_addr;
    @(negedge clk);
    ppu_rd = 1'b0;
  endtask

  task automatic prg_at(input logic [15:0] a, output logic [16:0] seen);
    @(negedge clk);
    cpu_addr = a;
    #1 seen = prg_rom_addr;
  endtask

  task automatic t_reset;
    logic [16:0] v;
    fetch(14'h0123, v); check("R1 lower bank", v, 17'h00123);
    fetch(14'h1456, v); check("R1 upper bank", v, 17'h00456);
    prg_at(16'h8000, v); check("R1 prg select", v, 17'h00000);
    check("R1 mirroring", mirror_horiz, 1'b0);
  endtask

  task automatic t_prg;
    logic [16:0] v;
    cpu_write(16'hA000, 8'hF7);
    prg_at(16'h8123, v); check("R2 switchable bank", v, 17'h0E123);
    cpu_write(16'h9000, 8'h05);
    prg_at(16'h8123, v); check("R8 low write ignored prg", v, 17'h0E123);
    cpu_write(16'hAFFF, 8'h02);
    prg_at(16'h9FFF, v); check("R2 top of window", v, 17'h05FFF);
  endtask

  task automatic t_fixed;
    logic [16:0] v;
    prg_at(16'hA010, v); check("R3 bank N-3", v, 17'h1A010);
    prg_at(16'hC020, v); check("R3 bank N-2", v, 17'h1C020);
    prg_at(16'hE030, v); check("R3 bank N-1", v, 17'h1E030);
  endtask

  task automatic t_banks;
    logic [16:0] v;
    cpu_write(16'hC000, 8'hE3);
    fetch(14'h0010, v); check("R4 lower FE immediate", v, 17'h03010);
    cpu_write(16'hB000, 8'h09);
    fetch(14'h0010, v); check("R4 lower FD hidden", v, 17'h03010);
    fetch(14'h0FD0, v); check("R5 trigger fetch old bank", v, 17'h03FD0);
    fetch(14'h0010, v); check("R5 lower FD applied", v, 17'h09010);
    fetch(14'h1010, v); check("R5 upper unaffected", v, 17'h00010);
    cpu_write(16'hE000, 8'h1F);
    fetch(14'h1010, v); check("R6 upper FE bank", v, 17'h1F010);
    cpu_write(16'hD000, 8'h04);
    fetch(14'h1FD8, v); check("R5 upper trigger old", v, 17'h1FFD8);
    fetch(14'h1000, v); check("R5 upper FD applied", v, 17'h04000);
    fetch(14'h1FE0, v); check("R5 upper FE trigger old", v, 17'h04FE0);
    fetch(14'h1000, v); check("R5 upper FE applied", v, 17'h1F000);
    fetch(14'h0FC0, v);
    fetch(14'h0000, v); check("R5 other tile no flip", v, 17'h09000);
    @(negedge clk); ppu_addr = 14'h0FE0;
    @(negedge clk);
    fetch(14'h0000, v); check("R5 no strobe no flip", v, 17'h09000);
    cpu_write(16'h8000, 8'h11);
    fetch(14'h0000, v); check("R8 low write ignored chr", v, 17'h09000);
    cpu_write(16'hB800, 8'h0A);
    fetch(14'h0ABC, v); check("R4 lower FD immediate", v, 17'h0AABC);
  endtask

  task automatic t_mirror;
    cpu_write(16'hF000, 8'h01);
    @(negedge clk); ppu_addr = 14'h2800;
    #1 check("R7 horizontal bit", mirror_horiz, 1'b1);
    check("R7 horizontal A11", nt_page, 1'b1);
    @(negedge clk); ppu_addr = 14'h2400;
    #1 check("R7 horizontal A10 ignored", nt_page, 1'b0);
    cpu_write(16'hFFFF, 8'hFE);
    @(negedge clk); ppu_addr = 14'h2400;
    #1 check("R7 vertical A10", nt_page, 1'b1);
    @(negedge clk); ppu_addr = 14'h2800;
    #1 check("R7 vertical A11 ignored", nt_page, 1'b0);
    check("R7 vertical bit", mirror_horiz, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prg();
    t_fixed();
    t_banks();
    t_mirror();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule